// File: doc/BRIEF.md
# Switch Release Pulse Generator

This block cleans up a single mechanical contact input so that it can drive the clock or count-enable of a downstream counter. The raw contact reads low while open and high while closed. Each press and release makes several quick open/close chatter cycles before the contacts come to rest. The block turns one full press-and-release into exactly one output pulse, one clock cycle wide. The pulse is issued when the contact has finished opening, not when it closes.

The raw level first passes through a two-flop synchronizer. A settle timer then watches the synchronized level. It accepts a new level only after that level has held, without interruption, for a run-time programmable number of clock cycles. Any return to the old level restarts the run. A release detector fires on the high-to-low change of the accepted level.

The settle count sets a trade-off. It must be longer than the longest chatter run, or chatter leaks through as extra pulses. It must be short enough that a quick real second actuation is still accepted. The lockout the block imposes is bounded by the settle count.

Top module: `switch_release_pulser`

## Requirements
- R1: While reset is high and in the cycles after reset is released with the contact open, `pulse_out` is low and no pulse is produced.
- R2: The raw input is sampled by two flops before any other logic uses it. With a settle count N, suppose the contact has been closed long enough to be accepted, and a clean open is first sampled at rising edge j. Then `pulse_out` is high for the clock cycle after rising edge j+N+2 and low in the cycles just before and after it.
- R3: The accepted level changes only after the synchronized input has differed from it for N consecutive cycles. Any cycle in which the input matches the accepted level again restarts that run.
- R4: Chatter runs shorter than N cycles, during the press or during the release, never produce extra pulses: one actuation gives exactly one pulse.
- R5: The pulse is one clock cycle wide and is produced only when the accepted level falls (release). Closing the contact and holding it closed produces no pulse.
- R6: A closure whose synchronized high run is shorter than N cycles is rejected and produces no pulse.
- R7: A settle count of 0 behaves as a settle count of 1.
- R8: Reset clears the accepted level to open and clears the settle run. A contact that was closed and accepted before reset, and opened while reset is high, produces no pulse after reset.
- R9: Back-to-back actuations that are closed for N cycles and then open for N cycles are each counted, one pulse apiece.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_raw | input | 1 | Raw contact level, high when closed, asynchronous |
| settle_cycles | input | SETTLE_W | Settle count N in clock cycles; 0 is treated as 1; change only while idle |
| pulse_out | output | 1 | One-cycle pulse per completed actuation, issued on release |

## Verification
The main function is driven with chatter trains of different run lengths against different settle counts. This includes runs of exactly N-1 cycles, which must still be rejected, and a settle count of 1, where a single-cycle closure is enough. A clean single actuation is timed edge by edge to separate a correct release-side pulse from one issued on press, from one issued late, and from one wider than a cycle. Several further patterns each expose a different fault. A closure shorter than the settle count shows whether short runs are wrongly accepted. Tight back-to-back actuations show an over-long lockout. A reset during a held closure shows whether stale state leaks out as a pulse.

// File: rtl/swdb_pkg.sv
package swdb_pkg;

    localparam int SETTLE_W_DEF   = 16;
    localparam int SYNC_DEPTH_DEF = 2;

    typedef enum logic [1:0] {
        LVL_STEADY = 2'd0,
        LVL_RISE   = 2'd1,
        LVL_FALL   = 2'd2
    } lvl_change_e;

    function automatic lvl_change_e classify_change(input logic prev, input logic cur);
        if (prev == cur)
            return LVL_STEADY;
        else if (cur)
            return LVL_RISE;
        else
            return LVL_FALL;
    endfunction

endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("sw_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/settle_filter.sv
module settle_filter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sync_in,
    input  logic [W-1:0] settle,
    output logic         level
);
    typedef struct packed {
        logic         level;
        logic [W-1:0] run;
    } flt_state_t;

    flt_state_t   cur, nxt;
    logic [W-1:0] limit;

    // A count of zero is treated as one (R7)
    assign limit = (settle == '0) ? W'(1) : settle;

    always_comb begin
        nxt = cur;
        if (sync_in == cur.level) begin
            nxt.run = '0;                       // run broken: restart (R3)
        end else if (cur.run >= limit - W'(1)) begin
            nxt.level = sync_in;
            nxt.run   = '0;
        end else begin
            nxt.run = cur.run + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;                          // R8
        else
            cur <= nxt;
    end

    assign level = cur.level;

    // R3: the accepted level only ever moves to the value last seen on the input
    p_flip_follows_input_r3: assert property (@(posedge clk) disable iff (rst)
        (level != $past(level)) |-> (level == $past(sync_in)));

endmodule

// File: rtl/release_edge.sv
module release_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic pulse
);
    import swdb_pkg::*;

    logic        prev;
    lvl_change_e chg;

    assign chg = classify_change(prev, level);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= 1'b0;
            pulse <= 1'b0;
        end else begin
            prev  <= level;
            pulse <= (chg == LVL_FALL);         // release only (R5)
        end
    end

endmodule

// File: rtl/switch_release_pulser.sv
module switch_release_pulser #(
    parameter int SETTLE_W   = swdb_pkg::SETTLE_W_DEF,
    parameter int SYNC_DEPTH = swdb_pkg::SYNC_DEPTH_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sw_raw,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output logic                pulse_out
);
    logic sync_level;
    logic flt_level;

    sw_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (sw_raw),
        .q_sync  (sync_level)
    );

    settle_filter #(.W(SETTLE_W)) u_filter (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_level),
        .settle  (settle_cycles),
        .level   (flt_level)
    );

    release_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (flt_level),
        .pulse (pulse_out)
    );

    // R5: never two pulse cycles in a row
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
        pulse_out |=> !pulse_out);

    // R1 / R8: first cycle out of reset is quiet
    p_reset_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pulse_out);

    // R4: a pulse is only issued after the synchronized contact has been seen open
    p_pulse_after_open_r4: assert property (@(posedge clk) disable iff (rst)
        pulse_out |-> !$past(sync_level, 2));

    // R1: the filtered level starts open
    p_level_open_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !flt_level);

endmodule

// File: tb/switch_release_pulser_bench.sv
module switch_release_pulser_bench;

    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sw_raw = 1'b0;
    logic [SW-1:0] settle_cycles = 16'd4;
    logic          pulse_out;

    int tests = 0;
    int fails = 0;
    int pulse_cnt = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    switch_release_pulser #(.SETTLE_W(SW)) u_switch_release_pulser (
        .clk           (clk),
        .rst           (rst),
        .sw_raw        (sw_raw),
        .settle_cycles (settle_cycles),
        .pulse_out     (pulse_out)
    );

    always @(negedge clk) if (pulse_out) pulse_cnt++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails++; tests++;
            $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // settle, bounce count, bounce run length, hold cycles, expected pulses
    typedef struct packed {
        logic [7:0] n;
        logic [7:0] b;
        logic [7:0] l;
        logic [7:0] h;
        logic [7:0] e;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{n:8'd4,  b:8'd0, l:8'd1,  h:8'd10, e:8'd1},   // R4 clean
        '{n:8'd4,  b:8'd3, l:8'd2,  h:8'd10, e:8'd1},   // R4 short chatter
        '{n:8'd8,  b:8'd5, l:8'd3,  h:8'd20, e:8'd1},   // R4
        '{n:8'd8,  b:8'd4, l:8'd7,  h:8'd20, e:8'd1},   // R3 runs of N-1 rejected
        '{n:8'd3,  b:8'd0, l:8'd1,  h:8'd2,  e:8'd0},   // R6 too short closure
        '{n:8'd1,  b:8'd0, l:8'd1,  h:8'd1,  e:8'd1},   // R3 minimum settle
        '{n:8'd16, b:8'd6, l:8'd15, h:8'd40, e:8'd1}    // R4 long chatter
    };

    task automatic actuate(input int b, input int l, input int h);
        for (int i = 0; i < b; i++) begin
            sw_raw = 1'b1; tick(l);
            sw_raw = 1'b0; tick(l);
        end
        sw_raw = 1'b1; tick(h);
        for (int i = 0; i < b; i++) begin
            sw_raw = 1'b0; tick(l);
            sw_raw = 1'b1; tick(l);
        end
        sw_raw = 1'b0; tick(h);
    endtask

    initial begin
        int base;
        int first_hi;
        int hi_cnt;

        // R1: reset state
        tick(3);
        check(pulse_out == 1'b0, "R1 pulse low in reset", pulse_out, 0);
        rst = 1'b0;
        tick(10);
        check(pulse_out == 1'b0 && pulse_cnt == 0, "R1 quiet after reset", pulse_cnt, 0);

        // table of chatter patterns
        for (int v = 0; v < NV; v++) begin
            settle_cycles = SW'(VEC[v].n);
            tick(2);
            base = pulse_cnt;
            actuate(int'(VEC[v].b), int'(VEC[v].l), int'(VEC[v].h));
            tick(int'(VEC[v].n) + 8);
            check(pulse_cnt - base == int'(VEC[v].e),
                  $sformatf("R4/R3/R6 vector %0d pulse count", v),
                  pulse_cnt - base, int'(VEC[v].e));
        end

        // R2 / R5: exact timing and width, nothing on press
        settle_cycles = 16'd5;
        tick(2);
        base = pulse_cnt;
        sw_raw = 1'b1;
        tick(15);
        check(pulse_cnt == base, "R5 no pulse on press", pulse_cnt - base, 0);
        sw_raw = 1'b0;
        first_hi = -1;
        hi_cnt = 0;
        for (int k = 1; k <= 14; k++) begin
            @(negedge clk);
            #0.5;
            if (pulse_out) begin
                hi_cnt++;
                if (first_hi < 0) first_hi = k;
            end
        end
        check(first_hi == 8, "R2 release latency N+3 negedges", first_hi, 8);
        check(hi_cnt == 1, "R5 pulse one cycle wide", hi_cnt, 1);

        // R7: settle 0 acts as 1
        settle_cycles = 16'd0;
        tick(2);
        base = pulse_cnt;
        sw_raw = 1'b1; tick(1);
        sw_raw = 1'b0; tick(8);
        check(pulse_cnt - base == 1, "R7 zero settle treated as one", pulse_cnt - base, 1);

        // R8: reset during an accepted closure, released while in reset
        settle_cycles = 16'd4;
        tick(2);
        base = pulse_cnt;
        sw_raw = 1'b1; tick(10);
        rst = 1'b1; tick(2);
        sw_raw = 1'b0; tick(2);
        rst = 1'b0; tick(15);
        check(pulse_cnt == base, "R8 no pulse after reset mid-actuation", pulse_cnt - base, 0);
        base = pulse_cnt;
        actuate(0, 1, 8);
        tick(10);
        check(pulse_cnt - base == 1, "R8 normal after reset", pulse_cnt - base, 1);

        // R9: tight back-to-back actuations
        settle_cycles = 16'd6;
        tick(2);
        base = pulse_cnt;
        for (int r = 0; r < 3; r++) begin
            sw_raw = 1'b1; tick(6);
            sw_raw = 1'b0; tick(6);
        end
        tick(12);
        check(pulse_cnt - base == 3, "R9 back-to-back actuations counted", pulse_cnt - base, 3);

        // R3: a single-cycle dropout during a closure restarts the run
        settle_cycles = 16'd5;
        tick(2);
        base = pulse_cnt;
        sw_raw = 1'b1; tick(4);
        sw_raw = 1'b0; tick(1);
        sw_raw = 1'b1; tick(4);
        sw_raw = 1'b0; tick(12);
        check(pulse_cnt == base, "R3 interrupted runs never accepted", pulse_cnt - base, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule